// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one output compare channel built around its own free-running up-counter. A prescaler advances the counter once every `PRE_DIV` bus clocks. Software loads a compare value of two bytes through separate high-byte and low-byte write strobes. It also loads a configuration word that holds the level to be driven on a match and an interrupt enable.

When the counter equals the compare value, the unit does three things. It sets a compare flag. It copies the programmed level into the output pin register. It raises an interrupt request if that is enabled. The compare is evaluated once for each counter value, so one match gives exactly one flag set and one level transfer.

A high-byte write suspends comparison until the low byte is written, which lets software change both halves without a false match in between. A low-byte write on its own never suspends comparison. Software clears the flag in two steps: it reads the status while the flag is set, then writes the low byte. The compare value and the flag are kept through reset.

Top module: `ocmp_timer`

## Requirements
- R1: After reset release, the internal reset takes two clock edges to end. From then on, `count` starts at 0 and increases by exactly one every `PRE_DIV` clock cycles, wrapping at its width.
- R2: Comparison is evaluated in the first clock cycle of each counter value. If `count` equals `cmp_val` and compares are not suspended, `cmp_flag` is 1 from the next clock edge.
- R3: On every match, the configured level is copied to `out_level`, including when `cmp_flag` is already 1. `out_level` changes at no other time except reset.
- R4: `irq` stays 0 while the interrupt enable bit (`cfg_ien`, loaded by `cfg_wr`) is 0, even when `cmp_flag` is 1.
- R5: A `hi_wr` pulse suspends compares. The counter can pass the compare value with no flag set until a `lo_wr` pulse is seen. If both strobes arrive in the same cycle, compares stay enabled.
- R6: A `lo_wr` pulse with no preceding `hi_wr` never suspends compares.
- R7: `hi_wr` replaces only the upper byte of `cmp_val`, and `lo_wr` replaces only the lower byte.
- R8: Reset leaves `cmp_val` and `cmp_flag` unchanged and ignores write strobes. It sets `count` and `out_level` to 0, and clears the level and enable configuration.
- R9: `cmp_flag` clears only on a `lo_wr` that follows a `stat_rd` made while the flag was 1. A `lo_wr` with no such read leaves the flag at 1.
- R10: A single counter value gives at most one flag set. If the flag is cleared while `count` still holds the matching value, it stays 0.
- R11: `irq` is 1 whenever both `cmp_flag` and the enable are 1, and it holds until the flag is cleared.
- R12: If a match and a clearing `lo_wr` fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_wr | input | 1 | Write strobe for the compare upper byte |
| lo_wr | input | 1 | Write strobe for the compare lower byte |
| wr_data | input | BYTE_W | Byte written by `hi_wr` or `lo_wr` |
| cfg_wr | input | 1 | Write strobe for the configuration |
| cfg_level | input | 1 | Level to drive on a match (loaded by `cfg_wr`) |
| cfg_ien | input | 1 | Interrupt enable (loaded by `cfg_wr`) |
| stat_rd | input | 1 | Status read strobe, first step of the flag clear |
| count | output | 2*BYTE_W | Free-running counter value |
| cmp_val | output | 2*BYTE_W | Current compare value |
| cmp_flag | output | 1 | Compare flag |
| out_level | output | 1 | Output pin level register |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in one cycle, and both are provoked on purpose. In the first, the flag is armed by a status read, and then a low-byte write is driven in exactly the cycle where the counter first shows the matching value. Setting the flag and clearing it then land together, and the flag must still read 1 afterwards. In the second, the flag is cleared during the remaining cycles of the matching counter value, and it must stay 0 until the counter moves on. The same cycle is also watched for a level transfer made while the flag is already set, with `out_level` compared against the newly configured level.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  // Configuration word loaded through cfg_wr
  typedef struct packed {
    logic level;  // value copied to the output pin on a match
    logic ien;    // interrupt enable
  } ocmp_cfg_t;

  localparam ocmp_cfg_t CFG_RESET = '{level: 1'b0, ien: 1'b0};

endpackage

// File: rtl/ocmp_prescale.sv
module ocmp_prescale #(
  parameter int PRE_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             eval
);

  localparam int          PW   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0]    div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  // next state
  always_comb begin
    tick  = (div_q == LAST);
    div_d = tick ? '0 : div_q + 1'b1;
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + CNT_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // first cycle of every counter value
  assign eval  = (div_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/ocmp_cmpreg.sv
module ocmp_cmpreg
  import ocmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic                cfg_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  ocmp_cfg_t           cfg_in,
  output logic [2*BYTE_W-1:0] cmp_val,
  output logic                inhibit,
  output ocmp_cfg_t           cfg
);

  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              inh_q, inh_d;
  ocmp_cfg_t         cfg_q, cfg_d;
  logic              hi_en, lo_en;

  assign hi_en = run & hi_wr;
  assign lo_en = run & lo_wr;

  // next state
  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    inh_d = inh_q;
    cfg_d = cfg_q;
    if (hi_en) begin
      hi_d  = wr_data;
      inh_d = 1'b1;
    end
    if (lo_en) begin
      lo_d  = wr_data;
      inh_d = 1'b0;
    end
    if (run && cfg_wr) cfg_d = cfg_in;
  end

  // compare value: kept through reset, updated only with a clock enable
  always_ff @(posedge clk) begin
    hi_q <= hi_d;
    lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
      cfg_q <= CFG_RESET;
    end else begin
      inh_q <= inh_d;
      cfg_q <= cfg_d;
    end
  end

  assign cmp_val = {hi_q, lo_q};
  assign inhibit = inh_q;
  assign cfg     = cfg_q;

endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag
  import ocmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      match,
  input  logic      lo_wr,
  input  logic      stat_rd,
  input  ocmp_cfg_t cfg,
  output logic      flag,
  output logic      pin,
  output logic      irq
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic pin_q, pin_d;

  // next state; a match overrides a simultaneous clear
  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    pin_d  = pin_q;
    if (lo_wr) begin
      arm_d = 1'b0;
      if (arm_q) flag_d = 1'b0;
    end else if (stat_rd && flag_q) begin
      arm_d = 1'b1;
    end
    if (match) begin
      flag_d = 1'b1;
      pin_d  = cfg.level;
    end
  end

  // flag is kept through reset: its clock enable is the run qualifier
  always_ff @(posedge clk) begin
    if (run) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      pin_q <= pin_d;
    end
  end

  assign flag = flag_q;
  assign pin  = pin_q;
  assign irq  = flag_q & cfg.ien;

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                cfg_wr,
  input  logic                cfg_level,
  input  logic                cfg_ien,
  input  logic                stat_rd,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] cmp_val,
  output logic                cmp_flag,
  output logic                out_level,
  output logic                irq
);

  localparam int CNT_W = 2 * BYTE_W;

  logic      rst_s1, rst_sync;
  logic      eval, inhibit, match;
  ocmp_cfg_t cfg_in, cfg_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  assign cfg_in = '{level: cfg_level, ien: cfg_ien};

  ocmp_prescale #(.PRE_DIV(PRE_DIV), .CNT_W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync),
    .count (count),
    .eval  (eval)
  );

  ocmp_cmpreg #(.BYTE_W(BYTE_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync),
    .run     (rst_sync),
    .hi_wr   (hi_wr),
    .lo_wr   (lo_wr),
    .cfg_wr  (cfg_wr),
    .wr_data (wr_data),
    .cfg_in  (cfg_in),
    .cmp_val (cmp_val),
    .inhibit (inhibit),
    .cfg     (cfg_q)
  );

  assign match = rst_sync & eval & ~inhibit & (count == cmp_val);

  ocmp_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync),
    .run     (rst_sync),
    .match   (match),
    .lo_wr   (lo_wr),
    .stat_rd (stat_rd),
    .cfg     (cfg_q),
    .flag    (cmp_flag),
    .pin     (out_level),
    .irq     (irq)
  );

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync,
  input logic             hi_wr,
  input logic             lo_wr,
  input logic             eval,
  input logic             inhibit,
  input logic             ien,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_val,
  input logic             cmp_flag,
  input logic             out_level,
  input logic             irq
);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    !$stable(count) |-> count == $past(count) + CNT_W'(1));

  p_flag_src_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(cmp_flag) |-> $past(eval && !inhibit && count == cmp_val));

  p_pin_src_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    !$stable(out_level) |-> $past(eval && !inhibit && count == cmp_val));

  p_irq_en_r4: assert property (@(posedge clk) disable iff (!rst_sync)
    !ien |-> !irq);

  p_hi_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    (hi_wr && !lo_wr) |=> inhibit);

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    inhibit |=> !$rose(cmp_flag));

  p_lo_enable_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    lo_wr |=> !inhibit);

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(2 * BYTE_W)) u_chk (
  .clk       (clk),
  .rst_sync  (rst_sync),
  .hi_wr     (hi_wr),
  .lo_wr     (lo_wr),
  .eval      (eval),
  .inhibit   (inhibit),
  .ien       (cfg_q.ien),
  .count     (count),
  .cmp_val   (cmp_val),
  .cmp_flag  (cmp_flag),
  .out_level (out_level),
  .irq       (irq)
);

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb_top;

  localparam int BW = 4;
  localparam int CW = 2 * BW;
  localparam int PD = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hi_wr, lo_wr, cfg_wr, cfg_level, cfg_ien, stat_rd;
  logic [BW-1:0] wr_data;
  logic [CW-1:0] count, cmp_val;
  logic          cmp_flag, out_level, irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ocmp_timer #(.BYTE_W(BW), .PRE_DIV(PD)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_wr     (hi_wr),
    .lo_wr     (lo_wr),
    .wr_data   (wr_data),
    .cfg_wr    (cfg_wr),
    .cfg_level (cfg_level),
    .cfg_ien   (cfg_ien),
    .stat_rd   (stat_rd),
    .count     (count),
    .cmp_val   (cmp_val),
    .cmp_flag  (cmp_flag),
    .out_level (out_level),
    .irq       (irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_hi(input logic [BW-1:0] d);
    @(negedge clk); hi_wr = 1'b1; wr_data = d;
    @(negedge clk); hi_wr = 1'b0;
  endtask

  task automatic wr_lo(input logic [BW-1:0] d);
    @(negedge clk); lo_wr = 1'b1; wr_data = d;
    @(negedge clk); lo_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic lvl, input logic ie);
    @(negedge clk); cfg_wr = 1'b1; cfg_level = lvl; cfg_ien = ie;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  // clear the flag (if set) and load a new compare value
  task automatic load_cmp(input logic [CW-1:0] v);
    rd_stat();
    wr_lo(v[BW-1:0]);
    wr_hi(v[CW-1:BW]);
    wr_lo(v[BW-1:0]);
  endtask

  // return at the negedge of the first cycle in which count newly equals v
  task automatic wait_cnt(input logic [CW-1:0] v);
    int n = 0;
    while (count == v && n < 3000) begin @(negedge clk); n++; end
    while (count != v && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk("wait_cnt", 16'(count), 16'(v));
  endtask

  logic [CW-1:0] v;
  logic          lvl;

  initial begin
    rst_n = 1'b0; hi_wr = 0; lo_wr = 0; cfg_wr = 0; cfg_level = 0; cfg_ien = 0;
    stat_rd = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: counter from reset, one step per PD clocks after a two-edge release
    for (int k = 0; k < 40; k++) begin
      chk("R1 count", 16'(count), 16'((k < 2) ? 0 : (k - 2) / PD));
      @(negedge clk);
    end
    chk("R8 out_level reset", 16'(out_level), 16'd0);

    // prime the flag to a known state
    load_cmp(8'h20);
    wait_cnt(8'h20);
    @(negedge clk);
    chk("R2 prime flag", 16'(cmp_flag), 16'd1);

    // R2/R3/R4/R11 sweep across compare values, levels and enables
    for (int i = 0; i < 16; i++) begin
      v = CW'(i * 16 + 5);
      wr_cfg(i[0], i[1]);
      load_cmp(v);
      wait_cnt(v);
      chk("R2 flag before match", 16'(cmp_flag), 16'd0);
      @(negedge clk);
      chk("R2 flag after match", 16'(cmp_flag), 16'd1);
      chk("R3 level", 16'(out_level), 16'(i[0]));
      if (i[1]) chk("R11 irq", 16'(irq), 16'd1);
      else      chk("R4 irq masked", 16'(irq), 16'd0);
    end

    // R7: byte independence
    load_cmp(8'h5A);
    wr_hi(4'h3);
    chk("R7 hi write keeps lo", 16'(cmp_val), 16'h3A);
    wr_lo(4'hC);
    chk("R7 lo write keeps hi", 16'(cmp_val), 16'h3C);

    // R11: irq held while the flag is set; R4: disabling drops it
    wr_cfg(1'b1, 1'b1);
    load_cmp(8'h40);
    wait_cnt(8'h40);
    @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R11 irq held", 16'(irq), 16'd1);
    wr_cfg(1'b1, 1'b0);
    chk("R4 irq off when disabled", 16'(irq), 16'd0);
    chk("R4 flag kept", 16'(cmp_flag), 16'd1);

    // R3: level transfers again with the flag already set
    wr_cfg(1'b0, 1'b0);
    wait_cnt(8'h40);
    chk("R3 old level before match", 16'(out_level), 16'd1);
    @(negedge clk);
    chk("R3 level with flag set", 16'(out_level), 16'd0);

    // R9: low write without prior status read does not clear
    wr_lo(4'h0);
    chk("R9 no clear without read", 16'(cmp_flag), 16'd1);
    rd_stat();
    wr_lo(4'h0);
    chk("R9 clear after read", 16'(cmp_flag), 16'd0);

    // R5: high write suspends compares until low write
    load_cmp(8'h80);
    wr_hi(4'h8);
    wait_cnt(8'h80);
    @(negedge clk);
    chk("R5 suspended no flag", 16'(cmp_flag), 16'd0);
    repeat (PD) @(negedge clk);
    chk("R5 suspended after pass", 16'(cmp_flag), 16'd0);
    wr_lo(4'h0);
    wait_cnt(8'h80);
    @(negedge clk);
    chk("R5 resumed", 16'(cmp_flag), 16'd1);

    // R6: low-only write changes the value and compares stay live
    rd_stat();
    wr_lo(4'h9);
    chk("R6 value", 16'(cmp_val), 16'h89);
    wait_cnt(8'h89);
    @(negedge clk);
    chk("R6 lo-only match", 16'(cmp_flag), 16'd1);

    // R10: clear while count still holds the matching value
    load_cmp(8'hA4);
    wait_cnt(8'hA4);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; lo_wr = 1'b1; wr_data = 4'h4;
    @(negedge clk); lo_wr = 1'b0;
    chk("R10 cleared in window", 16'(cmp_flag), 16'd0);
    repeat (2 * PD) @(negedge clk);
    chk("R10 no second set", 16'(cmp_flag), 16'd0);

    // R12: clearing write lands in the match cycle
    wait_cnt(8'hA4);
    @(negedge clk);
    chk("R12 setup flag", 16'(cmp_flag), 16'd1);
    rd_stat();
    wait_cnt(8'hA4);
    lo_wr = 1'b1; wr_data = 4'h4;
    @(negedge clk); lo_wr = 1'b0;
    chk("R12 set wins", 16'(cmp_flag), 16'd1);

    // R8: reset keeps compare value and flag
    wr_cfg(1'b1, 1'b1);
    wait_cnt(8'hA4);
    @(negedge clk);
    chk("R8 pre level", 16'(out_level), 16'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); hi_wr = 1'b1; wr_data = 4'hF;
    @(negedge clk); hi_wr = 1'b0; rst_n = 1'b1;
    chk("R8 flag kept", 16'(cmp_flag), 16'd1);
    chk("R8 cmp kept", 16'(cmp_val), 16'hA4);
    chk("R8 count reset", 16'(count), 16'd0);
    chk("R8 level reset", 16'(out_level), 16'd0);
    chk("R8 irq enable reset", 16'(irq), 16'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule